// File: doc/BRIEF.md
# Multiply Divide Flag Unit

This unit performs 32-bit integer multiplication and division, each in a signed and an unsigned form. It returns the low word of a product, or the quotient of a division, together with a carry flag and an overflow flag. It also returns a range-exception request when the flag that governs the operation is set and the caller has enabled overflow exceptions.

A caller pulses `start` with an operation code, two operands and the exception-enable bit. It then waits for the one-cycle `done` pulse. At that pulse, `result_we` tells the caller whether the destination register should take `result`. A multiply finishes in a single cycle. A division with a nonzero divisor runs a restoring divider that produces one quotient bit per cycle on operand magnitudes. A division by zero finishes at once and writes nothing.

Only one operation is in flight at a time. While a division is running, further start requests are dropped.

Top module: `muldiv_flag_unit`

## Requirements
- R1: Operation codes are 2'b00 signed multiply, 2'b01 unsigned multiply, 2'b10 signed divide and 2'b11 unsigned divide. For a multiply, `done` and `result_we` are high in the cycle after the clock edge that samples `start`. `result` then carries the low 32 bits of the 64-bit product, taken as signed or unsigned according to the code.
- R2: A signed multiply sets `overflow` when its 64-bit signed product is below -2^31 or above 2^31-1, and clears it otherwise.
- R3: Both multiplies set `carry` when the product of the zero-extended operands exceeds 0xFFFFFFFF, and clear it otherwise.
- R4: An unsigned multiply always clears `overflow` and never raises `range_exc`.
- R5: A signed multiply raises `range_exc` at its `done` exactly when `overflow` is set and the enable bit was high at start.
- R6: A division by a nonzero divisor presents its quotient with `done` in the 33rd cycle after the sampling edge, with `result_we` high and `carry` clear. A signed quotient truncates toward zero and takes the XOR of the operand signs. 0x80000000 divided by -1 gives 0x80000000.
- R7: A division by zero completes in the cycle after the sampling edge with `carry` set and `result_we` low, and `result` keeps its previous value.
- R8: Both divisions always clear `overflow`. They raise `range_exc` exactly when `carry` is set and the enable bit was high at start.
- R9: `done` is a single-cycle pulse. A `start` that arrives while a division is running is ignored and does not change that division's result or timing.
- R10: After reset, `done`, `result_we`, `range_exc`, `carry`, `overflow` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, sampled when idle |
| op | input | 2 | Operation code (see R1) |
| opa | input | 32 | First operand (multiplicand or dividend) |
| opb | input | 32 | Second operand (multiplier or divisor) |
| ovf_exc_en | input | 1 | Enables range-exception requests |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Product low word or quotient |
| result_we | output | 1 | Destination write enable, valid with done |
| carry | output | 1 | Carry flag from the last completed operation |
| overflow | output | 1 | Overflow flag from the last completed operation |
| range_exc | output | 1 | Range-exception request, valid with done |

## Verification
Most faults in the divider's partial remainder, quotient shift register or sign bit leave the iteration count alone. They show up only as a wrong quotient at the single `done` pulse, 33 cycles after start, so the vectors pair every sign combination with exact and inexact quotients. A fault in the step counter or the busy bit moves `done` away from cycle 33 or repeats it, and the per-operation latency count catches that. The registered flags and the held `result` after a zero divisor carry state across operations. A wrong hold therefore shows only when an operation that writes is followed directly by one that does not, and the bench runs exactly that sequence.

// File: rtl/muldiv_flag_unit.sv
module muldiv_flag_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             ovf_exc_en,
  output logic             done,
  output logic [WIDTH-1:0] result,
  output logic             result_we,
  output logic             carry,
  output logic             overflow,
  output logic             range_exc
);

  localparam int W2 = 2 * WIDTH;
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [1:0] OP_MUL  = 2'b00;
  localparam logic [1:0] OP_MULU = 2'b01;
  localparam logic [1:0] OP_DIV  = 2'b10;
  localparam logic [1:0] OP_DIVU = 2'b11;

  logic [W2-1:0] sprod, uprod;
  logic          s_ovf, u_cy;

  assign sprod = $signed({{WIDTH{opa[WIDTH-1]}}, opa}) * $signed({{WIDTH{opb[WIDTH-1]}}, opb});
  assign uprod = {{WIDTH{1'b0}}, opa} * {{WIDTH{1'b0}}, opb};
  assign s_ovf = ~((&sprod[W2-1:WIDTH-1]) | ~(|sprod[W2-1:WIDTH-1]));
  assign u_cy  = |uprod[W2-1:WIDTH];

  logic             is_sdiv, a_neg, b_neg;
  logic [WIDTH-1:0] mag_a, mag_b;

  assign is_sdiv = (op == OP_DIV);
  assign a_neg   = is_sdiv & opa[WIDTH-1];
  assign b_neg   = is_sdiv & opb[WIDTH-1];
  assign mag_a   = a_neg ? (~opa + 1'b1) : opa;
  assign mag_b   = b_neg ? (~opb + 1'b1) : opb;

  logic             busy, q_neg, ove_q;
  logic [1:0]       op_q;
  logic [CW-1:0]    cnt;
  logic [WIDTH-1:0] rem, quo, dvs;
  logic [WIDTH:0]   shl, diff;
  logic             ge;
  logic [WIDTH-1:0] rem_n, quo_n, qfin;

  assign shl   = {rem, quo[WIDTH-1]};
  assign diff  = shl - {1'b0, dvs};
  assign ge    = ~diff[WIDTH];
  assign rem_n = ge ? diff[WIDTH-1:0] : shl[WIDTH-1:0];
  assign quo_n = {quo[WIDTH-2:0], ge};
  assign qfin  = q_neg ? (~quo_n + 1'b1) : quo_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      result    <= '0;
      result_we <= 1'b0;
      carry     <= 1'b0;
      overflow  <= 1'b0;
      range_exc <= 1'b0;
      busy      <= 1'b0;
      q_neg     <= 1'b0;
      ove_q     <= 1'b0;
      op_q      <= OP_MUL;
      cnt       <= '0;
      rem       <= '0;
      quo       <= '0;
      dvs       <= '0;
    end else begin
      done      <= 1'b0;
      result_we <= 1'b0;
      range_exc <= 1'b0;
      if (busy) begin
        rem <= rem_n;
        quo <= quo_n;
        cnt <= cnt - 1'b1;
        if (cnt == '0) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          result    <= qfin;
          result_we <= 1'b1;
          carry     <= 1'b0;
          overflow  <= 1'b0;
        end
      end else if (start) begin
        op_q  <= op;
        ove_q <= ovf_exc_en;
        case (op)
          OP_MUL: begin
            done      <= 1'b1;
            result    <= sprod[WIDTH-1:0];
            result_we <= 1'b1;
            carry     <= u_cy;
            overflow  <= s_ovf;
            range_exc <= s_ovf & ovf_exc_en;
          end
          OP_MULU: begin
            done      <= 1'b1;
            result    <= uprod[WIDTH-1:0];
            result_we <= 1'b1;
            carry     <= u_cy;
            overflow  <= 1'b0;
          end
          default: begin
            if (opb == '0) begin
              done      <= 1'b1;
              carry     <= 1'b1;
              overflow  <= 1'b0;
              range_exc <= ovf_exc_en;
            end else begin
              busy  <= 1'b1;
              cnt   <= CW'(WIDTH - 1);
              rem   <= '0;
              quo   <= mag_a;
              dvs   <= mag_b;
              q_neg <= a_neg ^ b_neg;
            end
          end
        endcase
      end
    end
  end

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  a_r9_busy_progress: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !result_we) |-> (result == $past(result)));
  a_r7_zero_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q[1] && carry) |-> !result_we);
  a_r4_mulu_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_MULU) |-> (!overflow && !range_exc));
  a_r5_mul_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_MUL) |-> (range_exc == (overflow && ove_q)));
  a_r8_div_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == OP_DIV || op_q == OP_DIVU)) |-> !overflow);
  a_r8_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q[1]) |-> (range_exc == (carry && ove_q)));
  a_r9_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (result_we || range_exc) |-> done);

endmodule

// File: tb/test_muldiv_flag_unit.sv
module test_muldiv_flag_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opa = '0, opb = '0;
  logic        ovf_exc_en = 1'b0;
  logic        done, result_we, carry, overflow, range_exc;
  logic [31:0] result;

  always #5 clk = ~clk;

  muldiv_flag_unit #(.WIDTH(32)) i_muldiv_flag_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .ovf_exc_en(ovf_exc_en), .done(done), .result(result), .result_we(result_we),
    .carry(carry), .overflow(overflow), .range_exc(range_exc)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] last_res = '0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  localparam int NV = 19;
  localparam logic [66:0] VEC [NV] = '{
    {2'b00, 32'h00000003, 32'h00000005, 1'b0},
    {2'b00, 32'hFFFFFFFD, 32'h00000007, 1'b1},
    {2'b00, 32'h00010000, 32'h00010000, 1'b0},
    {2'b00, 32'h7FFFFFFF, 32'h00000002, 1'b1},
    {2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1},
    {2'b00, 32'h80000000, 32'hFFFFFFFF, 1'b1},
    {2'b01, 32'hFFFFFFFF, 32'h00000002, 1'b1},
    {2'b01, 32'h00001234, 32'h00005678, 1'b0},
    {2'b01, 32'h80000000, 32'h00000002, 1'b1},
    {2'b10, 32'h00000064, 32'h00000007, 1'b1},
    {2'b10, 32'hFFFFFF9C, 32'h00000007, 1'b0},
    {2'b10, 32'h00000064, 32'hFFFFFFF9, 1'b0},
    {2'b10, 32'hFFFFFF9C, 32'hFFFFFFF9, 1'b1},
    {2'b10, 32'h80000000, 32'hFFFFFFFF, 1'b1},
    {2'b10, 32'h00000007, 32'h00000064, 1'b0},
    {2'b11, 32'hFFFFFFFF, 32'h00000003, 1'b1},
    {2'b11, 32'h80000000, 32'h00000001, 1'b0},
    {2'b10, 32'h00000005, 32'h00000000, 1'b1},
    {2'b11, 32'h00000005, 32'h00000000, 1'b0}
  };

  task automatic run_op(input logic [1:0] op_i, input logic [31:0] a_i, input logic [31:0] b_i, input logic ove_i);
    longint sa, sb, sp, sq;
    logic [63:0] up;
    logic [31:0] er;
    logic ewe, ecy, eov, erx;
    int elat, cyc;
    string rq;
    sa = longint'($signed(a_i));
    sb = longint'($signed(b_i));
    sp = sa * sb;
    up = {32'b0, a_i} * {32'b0, b_i};
    er = last_res; ewe = 1'b1; ecy = 1'b0; eov = 1'b0; erx = 1'b0; elat = 1;
    case (op_i)
      2'b00: begin
        er = sp[31:0]; ecy = (up[63:32] != 0);
        eov = (sp < -64'sd2147483648) || (sp > 64'sd2147483647);
        erx = eov && ove_i; rq = "R1";
      end
      2'b01: begin
        er = up[31:0]; ecy = (up[63:32] != 0); rq = "R1";
      end
      default: begin
        if (b_i == 0) begin
          ewe = 1'b0; ecy = 1'b1; erx = ove_i; rq = "R7";
        end else begin
          if (op_i == 2'b10) begin sq = sa / sb; er = sq[31:0]; end
          else er = a_i / b_i;
          elat = 33; rq = "R6";
        end
      end
    endcase
    @(negedge clk);
    start = 1'b1; op = op_i; opa = a_i; opb = b_i; ovf_exc_en = ove_i;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(rq, "latency", cyc, elat);
    chk(rq, "result", result, er);
    chk(rq, "result_we", {31'b0, result_we}, {31'b0, ewe});
    chk(op_i[1] ? "R8" : "R3", "carry", {31'b0, carry}, {31'b0, ecy});
    chk(op_i == 2'b00 ? "R2" : (op_i == 2'b01 ? "R4" : "R8"), "overflow", {31'b0, overflow}, {31'b0, eov});
    chk(op_i == 2'b00 ? "R5" : (op_i == 2'b01 ? "R4" : "R8"), "range_exc", {31'b0, range_exc}, {31'b0, erx});
    if (ewe) last_res = er;
    @(negedge clk);
    chk("R9", "done pulse width", {31'b0, done}, 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pulses, at;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "done", {31'b0, done}, 32'd0);
    chk("R10", "result", result, 32'd0);
    chk("R10", "flags", {27'b0, result_we, carry, overflow, range_exc, 1'b0}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][66:65], VEC[i][64:33], VEC[i][32:1], VEC[i][0]);

    // R7: write, then zero divisor must keep that value
    run_op(2'b01, 32'h0000BEEF, 32'h00000001, 1'b0);
    run_op(2'b10, 32'h12345678, 32'h00000000, 1'b0);

    // R9: starts during a division are ignored
    @(negedge clk);
    start = 1'b1; op = 2'b11; opa = 32'd1000; opb = 32'd10; ovf_exc_en = 1'b0;
    @(negedge clk);
    start = 1'b0;
    pulses = 0; at = 0;
    for (int c = 1; c <= 40; c++) begin
      if (c == 5 || c == 10 || c == 20) begin
        start = 1'b1; op = 2'b00; opa = 32'd3; opb = 32'd3;
      end else start = 1'b0;
      if (done) begin
        pulses++; at = c;
        chk("R9", "result of busy division", result, 32'd100);
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R9", "done pulses", pulses, 32'd1);
    chk("R9", "done cycle", at, 32'd33);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule